// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

The block connects two 18-bit buses, an A side and a B side, with one independent data path in each direction. Each path has four controls of its own: an active-low output enable, an active-low clock enable, an active-high latch enable and a clock. A single master/slave storage cell per bit serves all three transfer styles. With the latch enable high the path is a plain wire. With the latch enable low and the clock enable low the path is a rising-edge register. When the latch enable falls while the clock is high, the path keeps the value present at that moment. With the clock enable high and the latch enable low, the stored value is frozen.

The A-side outputs are three-state: a data vector and a single drive enable. The B-side outputs are open drain. Each bit is a pull-low request that is active only when its path is enabled and the stored bit is 0. The environment resolves the B lines as a wired-AND with pull-ups, and presents the resolved level on the B input. The A-side input has bus hold. A bit that neither an outside driver nor the block's own A output is driving keeps the last level it carried.

Top module: `univ_bus_xcvr`

## Requirements
- R1: When a direction's output enable is 1, that direction releases its outputs whatever its other controls do (all pull-low bits 0 on B, drive enable 0 on A). Storage keeps working while the outputs are released.
- R2: With the latch enable at 1, the output equals the input of that direction, and the clock and clock enable have no effect.
- R3: With clock enable 0 and latch enable 0, a rising clock edge stores the input and presents it on the output.
- R4: With clock enable 0 and latch enable 0, the output does not change while the clock stays high or stays low, even if the input changes.
- R5: With clock enable 0 and the clock high, a falling latch enable keeps the input value present at the fall.
- R6: With clock enable 1 and latch enable 0, rising clock edges are ignored and the output keeps its value.
- R7: B-side pull-low bit i is 1 exactly when the A-to-B output enable is 0 and bit i of the A-to-B data is 0.
- R8: The A-to-B path sees the A output value when the A drive enable is 1. Otherwise each bit shows the A input where its external-drive flag is 1, and otherwise the last level it carried.
- R9: The B-to-A path behaves in the same way with its own four controls, and operating one direction leaves the state of the other unchanged.
- R10: An active-low reset clears both stored words and the bus-hold state to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous reset, active low |
| aIn | input | 18 | Level seen on the A lines from outside drivers |
| aExtDrive | input | 18 | Per bit, 1 when an outside driver is active on that A line |
| aOut | output | 18 | Data driven onto the A lines |
| aOutEn | output | 1 | Drive enable for all A lines |
| bIn | input | 18 | Resolved level of the B lines |
| bPullLow | output | 18 | Per bit, 1 pulls that B line low |
| abOeN | input | 1 | A-to-B output enable, active low |
| abCeN | input | 1 | A-to-B clock enable, active low |
| abLe | input | 1 | A-to-B latch enable, high is transparent |
| abClk | input | 1 | A-to-B clock |
| baOeN | input | 1 | B-to-A output enable, active low |
| baCeN | input | 1 | B-to-A clock enable, active low |
| baLe | input | 1 | B-to-A latch enable, high is transparent |
| baClk | input | 1 | B-to-A clock |

## Verification
The hardest state to reach from the ports is a bus-hold bit whose retained level was last put there by the block's own A output rather than by an outside driver. The stimulus first makes the B-to-A path transparent and loads a pattern through the B lines, with every external-drive flag at 0. It then releases the A output and opens the A-to-B path, so the pattern can only come from the hold state. A second hard spot is the low clock phase: the master half is open there, so the stimulus parks the clock low and moves the input before the next rising edge.

// File: rtl/ubx_pkg.sv
`timescale 1ns/1ps
package ubx_pkg;

  // Strobes from one direction's control decoder to its storage cell
  typedef struct packed {
    logic flowThru;    // output taken straight from the input
    logic masterOpen;  // first half of the storage cell follows the input
    logic slaveOpen;   // second half follows the first half
    logic driveOn;     // output stage active
  } pathCtl_t;

endpackage

// File: rtl/ubx_path_ctl.sv
`timescale 1ns/1ps
module ubx_path_ctl
  import ubx_pkg::*;
(
  input  logic     oeN,
  input  logic     ceN,
  input  logic     le,
  input  logic     clk,
  output pathCtl_t ctl
);

  logic clkGate;
  assign clkGate = ~ceN;

  // A high latch enable opens both halves and bypasses the cell.
  // Otherwise the enabled clock alternates the halves: low opens the
  // master, high opens the slave, so a rising edge stores the input.
  always_comb begin
    ctl.flowThru   = le;
    ctl.masterOpen = le | (clkGate & ~clk);
    ctl.slaveOpen  = le | (clkGate & clk);
    ctl.driveOn    = ~oeN;
  end

endmodule

// File: rtl/ubx_path_store.sv
`timescale 1ns/1ps
module ubx_path_store
  import ubx_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         rstN,
  input  pathCtl_t     ctl,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);

  logic [W-1:0] masterQ;
  logic [W-1:0] slaveQ;

  always_latch begin
    if (!rstN)               masterQ = '0;
    else if (ctl.masterOpen) masterQ = dIn;
  end

  always_latch begin
    if (!rstN)              slaveQ = '0;
    else if (ctl.slaveOpen) slaveQ = masterQ;
  end

  assign dOut = ctl.flowThru ? dIn : slaveQ;

endmodule

// File: rtl/ubx_bus_hold.sv
`timescale 1ns/1ps
module ubx_bus_hold #(
  parameter int W = 18
) (
  input  logic         rstN,
  input  logic [W-1:0] lineIn,
  input  logic [W-1:0] extDrive,
  input  logic         ownEn,
  input  logic [W-1:0] ownVal,
  output logic [W-1:0] lineVal
);

  logic [W-1:0] driven;
  logic [W-1:0] drvVal;
  logic [W-1:0] holdQ;

  assign driven = extDrive | {W{ownEn}};
  assign drvVal = ownEn ? ownVal : lineIn;

  for (genvar i = 0; i < W; i++) begin : g_keeper
    always_latch begin
      if (!rstN)          holdQ[i] = 1'b0;
      else if (driven[i]) holdQ[i] = drvVal[i];
    end
  end

  assign lineVal = (driven & drvVal) | (~driven & holdQ);

endmodule

// File: rtl/univ_bus_xcvr.sv
`timescale 1ns/1ps
module univ_bus_xcvr
  import ubx_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         rstN,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] aExtDrive,
  output logic [W-1:0] aOut,
  output logic         aOutEn,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] bPullLow,
  input  logic         abOeN,
  input  logic         abCeN,
  input  logic         abLe,
  input  logic         abClk,
  input  logic         baOeN,
  input  logic         baCeN,
  input  logic         baLe,
  input  logic         baClk
);

  pathCtl_t     abCtl;
  pathCtl_t     baCtl;
  logic [W-1:0] aLine;
  logic [W-1:0] abData;
  logic [W-1:0] baData;

  ubx_path_ctl u_abCtl (
    .oeN(abOeN), .ceN(abCeN), .le(abLe), .clk(abClk), .ctl(abCtl)
  );

  ubx_path_ctl u_baCtl (
    .oeN(baOeN), .ceN(baCeN), .le(baLe), .clk(baClk), .ctl(baCtl)
  );

  ubx_bus_hold #(.W(W)) u_hold (
    .rstN(rstN), .lineIn(aIn), .extDrive(aExtDrive),
    .ownEn(aOutEn), .ownVal(aOut), .lineVal(aLine)
  );

  ubx_path_store #(.W(W)) u_abStore (
    .rstN(rstN), .ctl(abCtl), .dIn(aLine), .dOut(abData)
  );

  ubx_path_store #(.W(W)) u_baStore (
    .rstN(rstN), .ctl(baCtl), .dIn(bIn), .dOut(baData)
  );

  // Open-drain B stage: a 0 is a pull request, a 1 releases the line
  assign bPullLow = {W{abCtl.driveOn}} & ~abData;

  // Three-state A stage
  assign aOut   = baData;
  assign aOutEn = baCtl.driveOn;

endmodule

// File: rtl/ubx_checker.sv
`timescale 1ns/1ps
module ubx_checker #(
  parameter int W = 18
) (
  input logic         rstN,
  input logic [W-1:0] aIn,
  input logic [W-1:0] aExtDrive,
  input logic [W-1:0] aOut,
  input logic         aOutEn,
  input logic [W-1:0] bIn,
  input logic [W-1:0] bPullLow,
  input logic         abOeN,
  input logic         abCeN,
  input logic         abLe,
  input logic         abClk,
  input logic         baOeN,
  input logic         baLe,
  input logic         baClk
);

  logic         capCond;
  logic [W-1:0] capData;
  logic         inhCond;
  logic [W-1:0] inhPull;

  always_ff @(posedge abClk or negedge rstN) begin
    if (!rstN) begin
      capCond <= 1'b0;
      capData <= '0;
      inhCond <= 1'b0;
      inhPull <= '0;
    end else begin
      capCond <= !abCeN && !abLe && (&aExtDrive) && !aOutEn;
      capData <= aIn;
      inhCond <= abCeN && !abLe && !abOeN;
      inhPull <= bPullLow;
    end
  end

  // R1
  ab_release_chk: assert property (@(posedge abClk) disable iff (!rstN)
    abOeN |-> bPullLow == '0);

  // R1
  ba_release_chk: assert property (@(posedge baClk) disable iff (!rstN)
    baOeN |-> !aOutEn);

  // R2
  ab_flow_chk: assert property (@(posedge abClk) disable iff (!rstN)
    (abLe && !abOeN && (&aExtDrive) && !aOutEn) |-> bPullLow == ~aIn);

  // R9
  ba_flow_chk: assert property (@(posedge baClk) disable iff (!rstN)
    (baLe && !baOeN) |-> (aOutEn && aOut == bIn));

  // R3
  ab_capture_chk: assert property (@(negedge abClk) disable iff (!rstN)
    (capCond && !abLe && !abOeN) |-> bPullLow == ~capData);

  // R6
  ab_inhibit_chk: assert property (@(negedge abClk) disable iff (!rstN)
    (inhCond && !abLe && !abOeN) |-> bPullLow == inhPull);

endmodule

bind univ_bus_xcvr ubx_checker #(.W(W)) u_ubx_checker (
  .rstN(rstN), .aIn(aIn), .aExtDrive(aExtDrive), .aOut(aOut),
  .aOutEn(aOutEn), .bIn(bIn), .bPullLow(bPullLow),
  .abOeN(abOeN), .abCeN(abCeN), .abLe(abLe), .abClk(abClk),
  .baOeN(baOeN), .baLe(baLe), .baClk(baClk)
);

// File: tb/univ_bus_xcvr_bench.sv
`timescale 1ns/1ps
module univ_bus_xcvr_bench;

  localparam int W = 18;

  typedef struct packed {
    logic         oeN;
    logic         ceN;
    logic         le;
    logic         pulse;
    logic [W-1:0] data;
    logic [W-1:0] expPull;
    logic [3:0]   req;
  } vec_t;

  // A-to-B walk; abClk idles high, outside drivers on, A output off
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b1, 1'b0, 18'h2A5C3, 18'h00000, 4'd1},  // R1 released
    '{1'b0, 1'b1, 1'b1, 1'b0, 18'h2A5C3, ~18'h2A5C3, 4'd2}, // R2 R7 flow
    '{1'b0, 1'b0, 1'b1, 1'b1, 18'h15A3C, ~18'h15A3C, 4'd2}, // R2 clock ignored
    '{1'b0, 1'b0, 1'b0, 1'b0, 18'h15A3C, ~18'h15A3C, 4'd5}, // R5 latch closes
    '{1'b0, 1'b0, 1'b0, 1'b0, 18'h3FFFF, ~18'h15A3C, 4'd4}, // R4 clock high
    '{1'b0, 1'b0, 1'b0, 1'b1, 18'h3FFFF, 18'h00000, 4'd3},  // R3 R7 all ones
    '{1'b0, 1'b1, 1'b0, 1'b1, 18'h0F0F0, 18'h00000, 4'd6},  // R6 inhibited
    '{1'b1, 1'b0, 1'b0, 1'b1, 18'h0F0F0, 18'h00000, 4'd1},  // R1 stores anyway
    '{1'b0, 1'b1, 1'b0, 1'b0, 18'h2A5C3, ~18'h0F0F0, 4'd3}  // R3 shows stored
  };

  logic         clk = 1'b0;
  logic         rstN;
  logic [W-1:0] aIn, aExtDrive, aOut, bIn, bPullLow, tbPull;
  logic         aOutEn;
  logic         abOeN, abCeN, abLe, abClk;
  logic         baOeN, baCeN, baLe, baClk;
  int           nChecks = 0;
  int           nErrors = 0;
  int           cycles = 0;

  always #10 clk = ~clk;

  // Wired-AND B bus with pull-ups, settled one step later
  always @(bPullLow or tbPull) bIn <= #1 ~(bPullLow | tbPull);

  univ_bus_xcvr #(.W(W)) u_univ_bus_xcvr (
    .rstN(rstN), .aIn(aIn), .aExtDrive(aExtDrive), .aOut(aOut),
    .aOutEn(aOutEn), .bIn(bIn), .bPullLow(bPullLow),
    .abOeN(abOeN), .abCeN(abCeN), .abLe(abLe), .abClk(abClk),
    .baOeN(baOeN), .baCeN(baCeN), .baLe(baLe), .baClk(baClk)
  );

  task automatic chk(input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic pulseAb();
    step(); abClk = 1'b0;
    step(); abClk = 1'b1;
  endtask

  task automatic pulseBa();
    step(); baClk = 1'b0;
    step(); baClk = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nErrors++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; aIn = '0; aExtDrive = '1; tbPull = '0;
    abOeN = 1'b0; abCeN = 1'b1; abLe = 1'b0; abClk = 1'b1;
    baOeN = 1'b0; baCeN = 1'b1; baLe = 1'b0; baClk = 1'b1;
    repeat (3) step();
    rstN = 1'b1;
    settle();
    // R10: cleared storage pulls every B line and drives zeros on A
    chk("R10 B pull", bPullLow, '1);
    chk("R10 A data", aOut, '0);
    chk("R10 A enable", {17'd0, aOutEn}, 18'd1);

    step(); baOeN = 1'b1;

    foreach (VECS[k]) begin
      step();
      aIn = VECS[k].data; abCeN = VECS[k].ceN; abOeN = VECS[k].oeN;
      step();
      abLe = VECS[k].le;
      if (VECS[k].pulse) pulseAb();
      settle();
      chk($sformatf("R%0d vec%0d", VECS[k].req, k), bPullLow, VECS[k].expPull);
    end

    // R3 then R4 with the clock parked low
    step(); abCeN = 1'b0; aIn = 18'h05A5A;
    pulseAb(); settle();
    chk("R3 capture", bPullLow, ~18'h05A5A);
    step(); abClk = 1'b0;
    step(); aIn = 18'h3A5A5;
    settle();
    chk("R4 clock low", bPullLow, ~18'h05A5A);
    step(); abClk = 1'b1;
    settle();
    chk("R3 rise after low", bPullLow, ~18'h3A5A5);

    // R9: B-to-A with its own controls
    step(); abOeN = 1'b1;
    step(); baOeN = 1'b0; baCeN = 1'b1; baLe = 1'b1; tbPull = ~18'h1D2E7;
    settle();
    chk("R9 R2 flow", aOut, 18'h1D2E7);
    chk("R9 enable", {17'd0, aOutEn}, 18'd1);
    step(); baCeN = 1'b0;
    step(); baLe = 1'b0;
    step(); tbPull = ~18'h2C5B9;
    settle();
    chk("R9 R5 latch", aOut, 18'h1D2E7);
    pulseBa(); settle();
    chk("R9 R3 edge", aOut, 18'h2C5B9);
    step(); baCeN = 1'b1; tbPull = ~18'h0A0F3;
    pulseBa(); settle();
    chk("R9 R6 inhibit", aOut, 18'h2C5B9);
    step(); baOeN = 1'b1;
    settle();
    chk("R9 R1 release", {17'd0, aOutEn}, 18'd0);
    step(); tbPull = '0; abOeN = 1'b0;
    settle();
    chk("R9 other path kept", bPullLow, ~18'h3A5A5);

    // R8: bus hold
    step(); abLe = 1'b1; aExtDrive = '1; aIn = 18'h3C0F5;
    settle();
    chk("R8 driven", bPullLow, ~18'h3C0F5);
    step(); aExtDrive = '0; aIn = 18'h00AA0;
    settle();
    chk("R8 all held", bPullLow, ~18'h3C0F5);
    step(); aExtDrive = 18'h000FF; aIn = 18'h12345;
    settle();
    chk("R8 mixed", bPullLow, ~18'h3C045);
    step(); abOeN = 1'b1; aExtDrive = '0;
    step(); baOeN = 1'b0; baLe = 1'b1; tbPull = ~18'h2B6D1;
    step(); step();
    baOeN = 1'b1;
    step(); tbPull = '0; abOeN = 1'b0;
    settle();
    chk("R8 own value held", bPullLow, ~18'h2B6D1);

    // R10: reset from a loaded state
    step(); abLe = 1'b0; baLe = 1'b0; baOeN = 1'b0; aExtDrive = '1;
    step(); rstN = 1'b0;
    settle();
    chk("R10 B after reset", bPullLow, '1);
    chk("R10 A after reset", aOut, '0);
    step(); rstN = 1'b1;
    step();

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule